// File: doc/BRIEF.md
# Set/Clear Interrupt Enable and Flag Register Pair

This block holds the interrupt state of a small peripheral interface: a seven-bit enable register and a seven-bit flag register, plus a combined interrupt request. Hardware sources raise flags with one-cycle pulses. One of these sources is the completion of a shift-register transfer, which has its own input. A flag stays set until software clears it. The interrupt request is high whenever any flag is set and its matching enable is also set.

Software reaches both registers through a simple synchronous register bus with one address bit. A write to the enable register does not load a value. The top data bit selects a mode: set the enable bits marked with a 1, or clear them. Enable bits written as 0 keep their value, so each driver can change its own sources without reading first. Writing 1 to a flag bit clears that flag, and writing 0 leaves it alone. A source can then signal again by raising the flag. An interrupt handler checks flag bit 2 to see whether the shift transfer caused the interrupt.

Top module: `sc_irq_regs`

## Requirements
- R1: After reset, all enables and flags are 0, `irq` is 0, and `bus_rdata` is 0x00.
- R2: A write to address 1 (enable register) with data bit 7 = 1 sets every enable bit whose data bit is 1. The other enable bits keep their value.
- R3: A write to address 1 with data bit 7 = 0 clears every enable bit whose data bit is 1. The other enable bits keep their value. Writing 0x7F in this way clears all seven enables.
- R4: A 1 on `evt_in[i]` at a clock edge sets flag i. The flag then stays set until software clears it.
- R5: A write to address 0 (flag register) clears each flag whose data bit is 1. Data bits that are 0 have no effect.
- R6: If an event pulse and a clearing write for the same flag arrive in the same cycle, the flag is left set.
- R7: A pulse on `shift_done` sets flag bit 2, the shift-complete source.
- R8: `irq` equals the OR over all sources of (flag AND enable). A flag-register read returns this value in bit 7 and the flags in bits 6..0.
- R9: An enable-register read returns bit 7 = 1 and the enables in bits 6..0.
- R10: Read data appears on `bus_rdata` in the cycle after the read request. It holds its value in every cycle that has no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = flag register, 1 = enable register |
| bus_wdata | input | 8 | Write data; bit 7 is the set/clear mode for enable writes |
| bus_rdata | output | 8 | Registered read data |
| evt_in | input | 7 | Event pulses, one per source |
| shift_done | input | 1 | Shift-transfer-complete pulse, feeds source 2 |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong enable bit shows up right after the edge that wrote it: `irq` changes for any source whose flag is set, and the next enable-register read returns the wrong value. A flag that is lost or stuck gives a flag-register read one cycle later whose bits 6..0 are wrong. It also gives a wrong bit 7 whenever the matching enable is on. The same-cycle event-and-clear case and the rule that bits written as 0 are left alone are tested with targeted stimulus. A wrong result there stays visible at the ports until the next write.

// File: rtl/sc_irq_pkg.sv
package sc_irq_pkg;
    // Register select on the one-bit bus address
    typedef enum logic {
        REG_FLAG   = 1'b0,
        REG_ENABLE = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/irq_en_bank.sv
module irq_en_bank #(
    parameter int unsigned N_SRC = 7,
    localparam int unsigned DW   = N_SRC + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    output logic [N_SRC-1:0] en_q
);
    typedef struct packed {
        logic [N_SRC-1:0] en;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_data[DW-1]) begin
                st_d.en = st_q.en | wr_data[N_SRC-1:0];
            end else begin
                st_d.en = st_q.en & ~wr_data[N_SRC-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_q = st_q.en;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int unsigned N_SRC     = 7,
    parameter int unsigned SHIFT_IDX = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_in,
    input  logic             shift_done,
    input  logic             clr_en,
    input  logic [N_SRC-1:0] clr_mask,
    output logic [N_SRC-1:0] flag_q
);
    typedef struct packed {
        logic [N_SRC-1:0] flag;
    } flag_state_t;

    flag_state_t      st_d, st_q;
    logic [N_SRC-1:0] raise;

    // Merge the dedicated shift-complete input into its source slot
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        if (i == SHIFT_IDX) begin : g_shift
            assign raise[i] = evt_in[i] | shift_done;
        end else begin : g_plain
            assign raise[i] = evt_in[i];
        end
    end

    always_comb begin
        st_d = st_q;
        if (clr_en) begin
            st_d.flag = st_d.flag & ~clr_mask;
        end
        // A new event wins over a clear in the same cycle
        st_d.flag = st_d.flag | raise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_q = st_q.flag;
endmodule

// File: rtl/irq_readback.sv
module irq_readback
    import sc_irq_pkg::*;
#(
    parameter int unsigned N_SRC = 7,
    localparam int unsigned DW   = N_SRC + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  reg_sel_e         rd_sel,
    input  logic [N_SRC-1:0] flags,
    input  logic [N_SRC-1:0] enables,
    output logic             irq,
    output logic [DW-1:0]    rdata
);
    typedef struct packed {
        logic [DW-1:0] rdata;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic      pend;

    assign pend = |(flags & enables);

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            unique case (rd_sel)
                REG_FLAG:   st_d.rdata = {pend, flags};
                REG_ENABLE: st_d.rdata = {1'b1, enables};
                default:    st_d.rdata = st_q.rdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq   = pend;
    assign rdata = st_q.rdata;
endmodule

// File: rtl/sc_irq_regs.sv
module sc_irq_regs
    import sc_irq_pkg::*;
#(
    parameter int unsigned N_SRC     = 7,
    parameter int unsigned SHIFT_IDX = 2,
    localparam int unsigned DW       = N_SRC + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic             bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [N_SRC-1:0] evt_in,
    input  logic             shift_done,
    output logic             irq
);
    reg_sel_e         sel;
    logic             wr_enable, wr_flag, rd_any;
    logic [N_SRC-1:0] en_vec, flag_vec;

    assign sel       = reg_sel_e'(bus_addr);
    assign wr_enable = bus_sel && bus_we && (sel == REG_ENABLE);
    assign wr_flag   = bus_sel && bus_we && (sel == REG_FLAG);
    assign rd_any    = bus_sel && !bus_we;

    irq_en_bank #(.N_SRC(N_SRC)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_enable),
        .wr_data (bus_wdata),
        .en_q    (en_vec)
    );

    irq_flag_bank #(.N_SRC(N_SRC), .SHIFT_IDX(SHIFT_IDX)) u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_in     (evt_in),
        .shift_done (shift_done),
        .clr_en     (wr_flag),
        .clr_mask   (bus_wdata[N_SRC-1:0]),
        .flag_q     (flag_vec)
    );

    irq_readback #(.N_SRC(N_SRC)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_any),
        .rd_sel  (sel),
        .flags   (flag_vec),
        .enables (en_vec),
        .irq     (irq),
        .rdata   (bus_rdata)
    );
endmodule

// File: rtl/sc_irq_regs_chk.sv
module sc_irq_regs_chk #(
    parameter int unsigned N_SRC     = 7,
    parameter int unsigned SHIFT_IDX = 2,
    localparam int unsigned DW       = N_SRC + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_we,
    input logic             bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic [DW-1:0]    bus_rdata,
    input logic [N_SRC-1:0] evt_in,
    input logic             shift_done,
    input logic             irq,
    input logic [N_SRC-1:0] en_vec,
    input logic [N_SRC-1:0] flag_vec
);
    logic             en_wr, fl_wr, rd;
    logic [N_SRC-1:0] wmask, raise_all;

    assign en_wr = bus_sel && bus_we && bus_addr;
    assign fl_wr = bus_sel && bus_we && !bus_addr;
    assign rd    = bus_sel && !bus_we;
    assign wmask = bus_wdata[N_SRC-1:0];
    always_comb begin
        raise_all = evt_in;
        raise_all[SHIFT_IDX] = evt_in[SHIFT_IDX] | shift_done;
    end

    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && bus_wdata[DW-1]) |=> ((en_vec & $past(wmask)) == $past(wmask)));

    // R3
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !bus_wdata[DW-1]) |=> ((en_vec & $past(wmask)) == '0));

    // R2
    en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (((en_vec ^ $past(en_vec)) & ~$past(wmask)) == '0));

    // R4
    flag_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_all != '0) |=> ((flag_vec & $past(raise_all)) == $past(raise_all)));

    // R5
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_wr |=> (($past(flag_vec) & ~$past(wmask) & ~flag_vec) == '0));

    // R9
    en_read_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr) |=> bus_rdata[DW-1]);

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(bus_rdata));
endmodule

bind sc_irq_regs sc_irq_regs_chk #(.N_SRC(N_SRC), .SHIFT_IDX(SHIFT_IDX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .evt_in     (evt_in),
    .shift_done (shift_done),
    .irq        (irq),
    .en_vec     (en_vec),
    .flag_vec   (flag_vec)
);

// File: tb/sc_irq_regs_bench.sv
`timescale 1ns/1ps
module sc_irq_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [6:0] evt_in = '0;
    logic       shift_done = 1'b0;
    logic       irq;
    int         checks = 0;
    int         errors = 0;

    always #2.5 clk = ~clk;

    sc_irq_regs u_sc_irq_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_in(evt_in), .shift_done(shift_done), .irq(irq)
    );

    typedef struct packed {
        logic       sel;
        logic       we;
        logic       addr;
        logic [7:0] wd;
        logic [6:0] evt;
        logic       sh;
        logic       chk_rd;
        logic [7:0] exp_rd;
        logic       exp_irq;
        logic [3:0] req;
    } vec_t;

    // sel we addr wdata evt sh chk exp_rd irq req
    localparam vec_t VECS [15] = '{
        '{1'b1,1'b1,1'b1,8'h85,7'h00,1'b0,1'b0,8'h00,1'b0,4'd2},  // R2 set 0,2
        '{1'b1,1'b0,1'b1,8'h00,7'h00,1'b0,1'b1,8'h85,1'b0,4'd9},  // R9
        '{1'b0,1'b0,1'b0,8'h00,7'h02,1'b0,1'b0,8'h00,1'b0,4'd4},  // R4 flag 1
        '{1'b1,1'b0,1'b0,8'h00,7'h00,1'b0,1'b1,8'h02,1'b0,4'd8},  // R8 no irq
        '{1'b0,1'b0,1'b0,8'h00,7'h04,1'b0,1'b0,8'h00,1'b1,4'd4},  // R4 flag 2
        '{1'b1,1'b0,1'b0,8'h00,7'h00,1'b0,1'b1,8'h86,1'b1,4'd8},  // R8 irq bit
        '{1'b1,1'b1,1'b0,8'h00,7'h00,1'b0,1'b0,8'h00,1'b1,4'd5},  // R5 zero write
        '{1'b1,1'b1,1'b0,8'h04,7'h00,1'b0,1'b0,8'h00,1'b0,4'd5},  // R5 clear 2
        '{1'b1,1'b1,1'b1,8'h82,7'h00,1'b0,1'b0,8'h00,1'b1,4'd2},  // R2 set 1
        '{1'b1,1'b1,1'b1,8'h01,7'h00,1'b0,1'b0,8'h00,1'b1,4'd3},  // R3 clear 0
        '{1'b1,1'b0,1'b1,8'h00,7'h00,1'b0,1'b1,8'h86,1'b1,4'd3},  // R3 readback
        '{1'b1,1'b1,1'b1,8'h7F,7'h00,1'b0,1'b0,8'h00,1'b0,4'd3},  // R3 all off
        '{1'b1,1'b0,1'b1,8'h00,7'h00,1'b0,1'b1,8'h80,1'b0,4'd3},  // R3 readback
        '{1'b1,1'b1,1'b0,8'h7F,7'h00,1'b0,1'b0,8'h00,1'b0,4'd5},  // R5 clear all
        '{1'b1,1'b0,1'b0,8'h00,7'h00,1'b0,1'b1,8'h00,1'b0,4'd5}   // R5 readback
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Drive one cycle of stimulus at a falling edge, return at the next falling edge
    task automatic step(input logic s, input logic w, input logic a,
                        input logic [7:0] wd, input logic [6:0] ev, input logic sh);
        bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = wd;
        evt_in = ev; shift_done = sh;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
        evt_in = '0; shift_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 rdata", bus_rdata, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        step(1, 0, 1, 8'h00, 7'h00, 0);
        chk("R1 enables", bus_rdata, 8'h80);
        step(1, 0, 0, 8'h00, 7'h00, 0);
        chk("R1 flags", bus_rdata, 8'h00);

        for (int i = 0; i < 15; i++) begin
            step(VECS[i].sel, VECS[i].we, VECS[i].addr, VECS[i].wd, VECS[i].evt, VECS[i].sh);
            chk($sformatf("R%0d vec%0d irq", VECS[i].req, i), {7'd0, irq}, {7'd0, VECS[i].exp_irq});
            if (VECS[i].chk_rd)
                chk($sformatf("R%0d vec%0d rdata", VECS[i].req, i), bus_rdata, VECS[i].exp_rd);
        end

        // R6: event and clear of the same flag together leave it set
        step(1, 1, 1, 8'h88, 7'h00, 0);
        step(1, 1, 0, 8'h08, 7'h08, 0);
        chk("R6 irq", {7'd0, irq}, 8'h01);
        step(1, 0, 0, 8'h00, 7'h00, 0);
        chk("R6 flags", bus_rdata, 8'h88);

        // R7: shift-complete lands in flag bit 2
        step(1, 1, 1, 8'h7F, 7'h00, 0);
        step(1, 1, 0, 8'h7F, 7'h00, 0);
        step(0, 0, 0, 8'h00, 7'h00, 1);
        chk("R7 irq masked", {7'd0, irq}, 8'h00);
        step(1, 0, 0, 8'h00, 7'h00, 0);
        chk("R7 flags", bus_rdata, 8'h04);
        step(1, 1, 1, 8'h84, 7'h00, 0);
        chk("R8 irq after enable", {7'd0, irq}, 8'h01);

        // R10: read data holds without a read request
        chk("R10 hold after write", bus_rdata, 8'h04);
        step(0, 0, 1, 8'h00, 7'h10, 0);
        chk("R10 hold idle", bus_rdata, 8'h04);
        step(1, 0, 0, 8'h00, 7'h00, 0);
        chk("R10 new read", bus_rdata, 8'h94);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule